// File: doc/BRIEF.md
# PLL Clock Switch Sequencer

This block is a hardware sequencer that brings a clock-multiplying PLL from power-off to being the system clock. It can also reprogram a PLL that is already running without ever clocking the chip from an unlocked oscillator. A one-cycle `start` pulse launches a sequence and latches the whole request: the reference source, divider, 4-bit loop-filter range, 2-bit oscillator range, multiplier, flash read-timing code and a frequency code. `retune` selects a cold bring-up (0) or a live retune (1). The sequencer drives the PLL control fields, the flash read-timing code, a cache/prefetch disable and the system-clock mux select. It watches a reference-stable flag and the PLL lock flag.

In a cold bring-up the sequence is: wait for a stable reference, pick the source, set flash timing, power the PLL and load divider, filter, oscillator range and multiplier. It then waits a settle interval of at least 5 µs, enables the PLL, waits for a fresh lock and moves the system clock onto the PLL. A retune first parks the system clock on the safe source and disables the PLL before rewriting it. It compares the new frequency code with the one in use to decide whether flash timing must rise before the change (speed-up) or fall after it (slow-down). Equal codes leave flash timing alone. All control pins are plain levels or pulses. There is no streaming data path, so there is no valid/ready interface and no back-pressure.

Top module: `pll_switch_seq`

## Requirements
- R1: After reset, pll_pwr, pll_en, sysclk_pll, cache_off, busy and err are 0, and flash_rt holds its all-ones (slowest) code.
- R2: A start pulse is taken only while the block is idle or in error. busy is 1 from the cycle after acceptance until the sequence completes or fails. A start while busy changes nothing and its request is never applied.
- R3: A cold bring-up waits while ref_stable is 0. It then updates, on consecutive steps, ref_sel, then flash_rt one cycle later, pll_pwr three cycles after ref_sel, and then pll_div, pll_filt, pll_ico and pll_mul at four, five, six and seven cycles after ref_sel. pll_en is never 1 while pll_pwr is 0.
- R4: pll_en rises exactly SETTLE_CYC+1 cycles after pll_mul takes its new value, where SETTLE_CYC = ceil(CLK_KHZ*SETTLE_US/1000). This gives at least 5 µs at the sequencer clock.
- R5: sysclk_pll goes to 1 only after pll_lock makes a 0-to-1 transition while pll_en is 1. It rises two cycles after pll_lock rises. A lock flag that is already high at enable does not count.
- R6: In a retune, sysclk_pll falls two cycles before ref_sel is updated. pll_en is 0 whenever pll_div, pll_filt, pll_ico or pll_mul change, and pll_div changes one cycle after pll_en falls.
- R7: In a retune where the new frequency code is greater than the current one, flash_rt takes its new value two cycles before pll_en falls, with sysclk_pll at 0.
- R8: In a retune where the new frequency code is smaller, flash_rt keeps its old value until one cycle after sysclk_pll returns to 1, and takes the new value then.
- R9: In a retune where the frequency codes are equal, flash_rt does not change.
- R10: cache_off is 1 in the cycle before and the cycle after every decrease of flash_rt, and stays 0 through a sequence that does not lower it.
- R11: If no lock rise arrives within LOCK_TMO cycles of pll_en rising, err rises exactly LOCK_TMO cycles after pll_en, busy drops, and sysclk_pll stays 0. The next accepted start clears err one cycle later.
- R12: After a completed sequence, ref_sel, pll_div, pll_filt, pll_ico and pll_mul equal the values latched with the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (the safe system clock) |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches a sequence |
| retune | input | 1 | 0: cold bring-up, 1: live retune |
| req_src | input | 1 | Requested PLL reference source |
| req_div | input | DIV_W | Requested reference divider |
| req_filt | input | 4 | Requested loop-filter range |
| req_ico | input | 2 | Requested oscillator range |
| req_mul | input | MUL_W | Requested multiplier |
| req_flrt | input | FLRT_W | Requested flash read-timing code |
| req_freq | input | FREQ_W | Code of the requested output frequency |
| ref_stable | input | 1 | Reference clock is running and stable |
| pll_lock | input | 1 | PLL lock flag |
| pll_pwr | output | 1 | PLL power enable |
| pll_en | output | 1 | PLL enable |
| ref_sel | output | 1 | PLL reference select |
| pll_div | output | DIV_W | Divider to the PLL |
| pll_mul | output | MUL_W | Multiplier to the PLL |
| pll_filt | output | 4 | Loop-filter range to the PLL |
| pll_ico | output | 2 | Oscillator range to the PLL |
| flash_rt | output | FLRT_W | Flash read-timing code |
| cache_off | output | 1 | Cache reads/writes and prefetch disabled |
| sysclk_pll | output | 1 | 1: system clock from PLL, 0: safe source |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Lock timeout occurred |

## Verification
Every result has a fixed cycle distance from its trigger. ref_sel and the PLL fields follow one another at fixed one-cycle steps. pll_en follows pll_mul by SETTLE_CYC+1 cycles, sysclk_pll follows a lock rise by two cycles, and err follows pll_en by LOCK_TMO cycles. The bench records the cycle number at which each output changes, sampling shortly after each rising edge. It then checks the exact distances and orderings from the requirements instead of polling loosely. Stimulus is applied on falling edges, and spot values are read on falling edges at the cycle counts worked out above.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int FILT_W = 4;
  localparam int ICO_W  = 2;

  typedef enum logic [4:0] {
    S_IDLE, S_PARK, S_WREF, S_SRC, S_PRE_FL, S_PRE_HOLD, S_GATE,
    S_DIV, S_FILT, S_ICO, S_MUL, S_SETTLE, S_ENA, S_LOCK,
    S_SWITCH, S_POST_FL, S_POST_HOLD, S_ERR
  } seq_state_e;

  // Flash timing plan decided once when a request is accepted
  typedef struct packed {
    logic wr_pre;   // write the code before touching the PLL
    logic wr_post;  // write the code after the clock switch
    logic lower;    // new code is below the one in force
  } flash_plan_t;

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  // done is high in the LIMIT-th cycle of an uninterrupted run
  assign done = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_plan.sv
module pll_seq_plan
  import pll_seq_pkg::*;
#(
  parameter int FREQ_W = 4,
  parameter int FLRT_W = 2
) (
  input  logic              retune,
  input  logic [FREQ_W-1:0] new_freq,
  input  logic [FREQ_W-1:0] cur_freq,
  input  logic [FLRT_W-1:0] new_flrt,
  input  logic [FLRT_W-1:0] cur_flrt,
  output flash_plan_t       plan
);
  logic faster, slower;

  assign faster = new_freq > cur_freq;
  assign slower = new_freq < cur_freq;

  always_comb begin
    // cold start always programs timing before the PLL runs
    plan.wr_pre  = !retune || faster;
    plan.wr_post = retune && slower;
    plan.lower   = new_flrt < cur_flrt;
  end
endmodule

// File: rtl/pll_switch_seq.sv
module pll_switch_seq
  import pll_seq_pkg::*;
#(
  parameter int DIV_W     = 5,
  parameter int MUL_W     = 6,
  parameter int FLRT_W    = 2,
  parameter int FREQ_W    = 4,
  parameter int CLK_KHZ   = 50000,
  parameter int SETTLE_US = 5,
  parameter int LOCK_TMO  = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retune,
  input  logic              req_src,
  input  logic [DIV_W-1:0]  req_div,
  input  logic [FILT_W-1:0] req_filt,
  input  logic [ICO_W-1:0]  req_ico,
  input  logic [MUL_W-1:0]  req_mul,
  input  logic [FLRT_W-1:0] req_flrt,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic              ref_stable,
  input  logic              pll_lock,
  output logic              pll_pwr,
  output logic              pll_en,
  output logic              ref_sel,
  output logic [DIV_W-1:0]  pll_div,
  output logic [MUL_W-1:0]  pll_mul,
  output logic [FILT_W-1:0] pll_filt,
  output logic [ICO_W-1:0]  pll_ico,
  output logic [FLRT_W-1:0] flash_rt,
  output logic              cache_off,
  output logic              sysclk_pll,
  output logic              busy,
  output logic              err
);
  localparam int SETTLE_RAW = (CLK_KHZ * SETTLE_US + 999) / 1000;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;

  seq_state_e state, nxt;

  // latched request
  logic              retune_q, src_q;
  logic [DIV_W-1:0]  div_q;
  logic [FILT_W-1:0] filt_q;
  logic [ICO_W-1:0]  ico_q;
  logic [MUL_W-1:0]  mul_q;
  logic [FLRT_W-1:0] flrt_q;
  logic [FREQ_W-1:0] freq_q, cur_freq;
  flash_plan_t       plan_now, plan_q;

  logic lock_q, lock_rise, settle_done, lock_tmo, accept;

  pll_seq_plan #(.FREQ_W(FREQ_W), .FLRT_W(FLRT_W)) u_plan (
    .retune   (retune),
    .new_freq (req_freq),
    .cur_freq (cur_freq),
    .new_flrt (req_flrt),
    .cur_flrt (flash_rt),
    .plan     (plan_now)
  );

  pll_seq_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk (clk), .rst_n (rst_n), .run (state == S_SETTLE), .done (settle_done)
  );

  pll_seq_timer #(.LIMIT(LOCK_TMO)) u_lock_tmo (
    .clk (clk), .rst_n (rst_n), .run (state == S_LOCK), .done (lock_tmo)
  );

  assign lock_rise = pll_lock && !lock_q;
  assign accept    = start && (state == S_IDLE || state == S_ERR);
  assign busy      = (state != S_IDLE) && (state != S_ERR);
  assign err       = (state == S_ERR);
  assign cache_off = plan_q.lower &&
                     ((plan_q.wr_pre  && (state == S_PRE_FL  || state == S_PRE_HOLD)) ||
                      (plan_q.wr_post && (state == S_POST_FL || state == S_POST_HOLD)));

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE, S_ERR: if (start) nxt = retune ? S_PARK : S_WREF;
      S_PARK:      nxt = S_WREF;
      S_WREF:      if (ref_stable) nxt = S_SRC;
      S_SRC:       nxt = S_PRE_FL;
      S_PRE_FL:    nxt = S_PRE_HOLD;
      S_PRE_HOLD:  nxt = S_GATE;
      S_GATE:      nxt = S_DIV;
      S_DIV:       nxt = S_FILT;
      S_FILT:      nxt = S_ICO;
      S_ICO:       nxt = S_MUL;
      S_MUL:       nxt = S_SETTLE;
      S_SETTLE:    if (settle_done) nxt = S_ENA;
      S_ENA:       nxt = S_LOCK;
      S_LOCK: begin
        if (lock_rise)     nxt = S_SWITCH;
        else if (lock_tmo) nxt = S_ERR;
      end
      S_SWITCH:    nxt = plan_q.wr_post ? S_POST_FL : S_IDLE;
      S_POST_FL:   nxt = S_POST_HOLD;
      S_POST_HOLD: nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      lock_q     <= 1'b0;
      retune_q   <= 1'b0;
      src_q      <= 1'b0;
      div_q      <= '0;
      filt_q     <= '0;
      ico_q      <= '0;
      mul_q      <= '0;
      flrt_q     <= '0;
      freq_q     <= '0;
      cur_freq   <= '0;
      plan_q     <= '0;
      pll_pwr    <= 1'b0;
      pll_en     <= 1'b0;
      ref_sel    <= 1'b0;
      pll_div    <= '0;
      pll_mul    <= '0;
      pll_filt   <= '0;
      pll_ico    <= '0;
      flash_rt   <= '1;
      sysclk_pll <= 1'b0;
    end else begin
      state  <= nxt;
      lock_q <= pll_lock;
      if (accept) begin
        retune_q <= retune;
        src_q    <= req_src;
        div_q    <= req_div;
        filt_q   <= req_filt;
        ico_q    <= req_ico;
        mul_q    <= req_mul;
        flrt_q   <= req_flrt;
        freq_q   <= req_freq;
        plan_q   <= plan_now;
      end
      case (state)
        S_PARK:   sysclk_pll <= 1'b0;
        S_SRC:    ref_sel    <= src_q;
        S_PRE_FL: if (plan_q.wr_pre) flash_rt <= flrt_q;
        S_GATE: begin
          pll_pwr <= 1'b1;
          pll_en  <= 1'b0;
        end
        S_DIV:    pll_div  <= div_q;
        S_FILT:   pll_filt <= filt_q;
        S_ICO:    pll_ico  <= ico_q;
        S_MUL:    pll_mul  <= mul_q;
        S_ENA:    pll_en   <= 1'b1;
        S_SWITCH: begin
          sysclk_pll <= 1'b1;
          cur_freq   <= freq_q;
        end
        S_POST_FL: if (plan_q.wr_post) flash_rt <= flrt_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int DIV_W      = 5,
  parameter int MUL_W      = 6,
  parameter int FLRT_W     = 2,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pll_pwr,
  input logic              pll_en,
  input logic              pll_lock,
  input logic [DIV_W-1:0]  pll_div,
  input logic [MUL_W-1:0]  pll_mul,
  input logic [3:0]        pll_filt,
  input logic [1:0]        pll_ico,
  input logic [FLRT_W-1:0] flash_rt,
  input logic              cache_off,
  input logic              sysclk_pll,
  input logic              busy,
  input logic              err
);
  localparam int CW = $clog2(SETTLE_CYC + 2);

  logic [MUL_W-1:0] mul_prev;
  logic [CW-1:0]    since_mul;

  // cycles elapsed since the multiplier last changed, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mul_prev  <= '0;
      since_mul <= '0;
    end else begin
      mul_prev <= pll_mul;
      if (pll_mul != mul_prev)               since_mul <= '0;
      else if (since_mul != CW'(SETTLE_CYC)) since_mul <= since_mul + 1'b1;
    end
  end

  AST_EN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> pll_pwr); // R3

  AST_SETTLE_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> since_mul >= CW'(SETTLE_CYC)); // R4

  AST_SWITCH_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysclk_pll) |-> $past(pll_en) && $past(pll_lock)); // R5

  AST_CFG_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pll_div) || !$stable(pll_mul) || !$stable(pll_filt) || !$stable(pll_ico))
      |-> !pll_en && !sysclk_pll); // R6

  AST_RAISE_ON_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rt > $past(flash_rt)) |-> !sysclk_pll); // R7

  AST_CACHE_AT_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rt < $past(flash_rt)) |-> cache_off && $past(cache_off)); // R10

  AST_ERR_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !sysclk_pll && !busy); // R11

endmodule

bind pll_switch_seq pll_seq_chk #(
  .DIV_W(DIV_W), .MUL_W(MUL_W), .FLRT_W(FLRT_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (.*);

// File: tb/sim_pll_switch_seq.sv
module sim_pll_switch_seq;
  localparam int CLK_KHZ    = 50000;
  localparam int EXP_SETTLE = (CLK_KHZ * 5 + 999) / 1000;
  localparam int EXP_TMO    = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, retune = 0, req_src = 0, ref_stable = 0, pll_lock = 0;
  logic [4:0] req_div = 0;
  logic [3:0] req_filt = 0;
  logic [1:0] req_ico = 0;
  logic [5:0] req_mul = 0;
  logic [1:0] req_flrt = 0;
  logic [3:0] req_freq = 0;
  logic pll_pwr, pll_en, ref_sel, cache_off, sysclk_pll, busy, err;
  logic [4:0] pll_div;
  logic [5:0] pll_mul;
  logic [3:0] pll_filt;
  logic [1:0] pll_ico, flash_rt;

  always #2 clk = ~clk;

  pll_switch_seq u0 (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;

  // change monitor, sampling 1 ns after each rising edge
  int cyc = 0;
  int c_ref, c_flrt, c_pwr, c_div, c_filt, c_ico, c_mul;
  int c_enrise, c_enfall, c_sysrise, c_sysfall, c_err, cache_cyc;
  bit cache_bad;
  logic p_ref, p_pwr, p_en, p_sys, p_err, p_cache;
  logic [4:0] p_div; logic [5:0] p_mul; logic [3:0] p_filt; logic [1:0] p_ico, p_flrt;

  task automatic clear_marks();
    c_ref = -1; c_flrt = -1; c_pwr = -1; c_div = -1; c_filt = -1; c_ico = -1;
    c_mul = -1; c_enrise = -1; c_enfall = -1; c_sysrise = -1; c_sysfall = -1;
    c_err = -1; cache_cyc = 0; cache_bad = 0;
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    if (ref_sel !== p_ref)   c_ref  = cyc;
    if (flash_rt !== p_flrt) begin
      c_flrt = cyc;
      if (flash_rt < p_flrt && !(cache_off && p_cache)) cache_bad = 1;
    end
    if (pll_pwr !== p_pwr)   c_pwr  = cyc;
    if (pll_div !== p_div)   c_div  = cyc;
    if (pll_filt !== p_filt) c_filt = cyc;
    if (pll_ico !== p_ico)   c_ico  = cyc;
    if (pll_mul !== p_mul)   c_mul  = cyc;
    if (pll_en && !p_en)     c_enrise = cyc;
    if (!pll_en && p_en)     c_enfall = cyc;
    if (sysclk_pll && !p_sys) c_sysrise = cyc;
    if (!sysclk_pll && p_sys) c_sysfall = cyc;
    if (err && !p_err)       c_err = cyc;
    if (cache_off)           cache_cyc++;
    p_ref = ref_sel; p_flrt = flash_rt; p_pwr = pll_pwr; p_div = pll_div;
    p_filt = pll_filt; p_ico = pll_ico; p_mul = pll_mul; p_en = pll_en;
    p_sys = sysclk_pll; p_err = err; p_cache = cache_off;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic set_req(input bit rt, input bit s, input int d, input int f,
                         input int i, input int m, input int fl, input int fq);
    retune = rt; req_src = s; req_div = 5'(d); req_filt = 4'(f); req_ico = 2'(i);
    req_mul = 6'(m); req_flrt = 2'(fl); req_freq = 4'(fq);
  endtask

  task automatic wait_en(input logic v);
    for (int n = 0; n < 5000 && pll_en !== v; n++) @(negedge clk);
  endtask

  task automatic lock_and_switch(input string tag);
    @(negedge clk) pll_lock = 1'b1;
    @(negedge clk);
    chk({tag, " sysclk one cycle after lock rise"}, sysclk_pll, 0);
    @(negedge clk);
    chk({tag, " sysclk two cycles after lock rise"}, sysclk_pll, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pwr", pll_pwr, 0);
    chk("R1 en", pll_en, 0);
    chk("R1 sysclk", sysclk_pll, 0);
    chk("R1 flash code", flash_rt, 3);
    chk("R1 busy/err/cache", {busy, err, cache_off}, 0);
  endtask

  task automatic t_cold();
    clear_marks();
    ref_stable = 0; pll_lock = 0;
    set_req(0, 1, 5, 9, 2, 20, 1, 6);
    fire();
    chk("R2 busy after accept", busy, 1);
    repeat (5) @(negedge clk);
    chk("R3 holds while reference unstable", c_ref, -1);
    ref_stable = 1;
    for (int n = 0; n < 100 && pll_mul != 20; n++) @(negedge clk);
    // second start during the settle wait must be ignored
    set_req(1, 0, 7, 1, 1, 33, 3, 2);
    fire();
    set_req(0, 1, 5, 9, 2, 20, 1, 6);
    wait_en(1);
    chk("R3 flash after source", c_flrt - c_ref, 1);
    chk("R3 power", c_pwr - c_ref, 3);
    chk("R3 divider", c_div - c_ref, 4);
    chk("R3 filter", c_filt - c_ref, 5);
    chk("R3 osc range", c_ico - c_ref, 6);
    chk("R3 multiplier", c_mul - c_ref, 7);
    chk("R4 settle before enable", c_enrise - c_mul, EXP_SETTLE + 1);
    repeat (6) @(negedge clk);
    chk("R5 no switch before lock", sysclk_pll, 0);
    lock_and_switch("R5 cold");
    chk("R2 busy cleared at completion", busy, 0);
    chk("R12 div", pll_div, 5);
    chk("R12 mul (ignored start R2)", pll_mul, 20);
    chk("R12 filt/ico/src", {pll_filt, pll_ico, ref_sel}, {4'd9, 2'd2, 1'b1});
    chk("R10 flash lowered", flash_rt, 1);
    chk("R10 cache held around lowering", cache_bad, 0);
    chk("R10 cache asserted", cache_cyc, 2);
  endtask

  task automatic t_up();
    clear_marks();
    set_req(1, 0, 6, 10, 3, 24, 2, 9);
    fire();
    wait_en(0);
    pll_lock = 0;
    wait_en(1);
    repeat (3) @(negedge clk);
    lock_and_switch("R5 retune up");
    chk("R6 park before source", c_ref - c_sysfall, 2);
    chk("R6 div after disable", c_div - c_enfall, 1);
    chk("R7 flash before disable", c_enfall - c_flrt, 2);
    chk("R7 flash value", flash_rt, 2);
    chk("R10 no cache when raising", cache_cyc, 0);
  endtask

  task automatic t_down();
    clear_marks();
    set_req(1, 1, 4, 3, 1, 12, 0, 3);
    fire();
    wait_en(0);
    pll_lock = 0;
    wait_en(1);
    repeat (3) @(negedge clk);
    lock_and_switch("R5 retune down");
    @(negedge clk);
    chk("R8 flash after switch", c_flrt - c_sysrise, 1);
    chk("R8 flash value", flash_rt, 0);
    chk("R10 cache around lowering", cache_bad, 0);
    chk("R10 cache cycles", cache_cyc, 2);
    chk("R12 retune fields", {pll_div, pll_mul}, {5'd4, 6'd12});
  endtask

  task automatic t_equal();
    clear_marks();
    pll_lock = 1;   // stays high across the disable: stale lock
    set_req(1, 0, 3, 4, 0, 13, 3, 3);
    fire();
    wait_en(0);
    wait_en(1);
    repeat (20) @(negedge clk);
    chk("R5 stale lock ignored", sysclk_pll, 0);
    @(negedge clk) pll_lock = 0;
    lock_and_switch("R5 fresh lock");
    repeat (3) @(negedge clk);
    chk("R9 flash unchanged", flash_rt, 0);
    chk("R9 no flash write", c_flrt, -1);
  endtask

  task automatic t_timeout();
    clear_marks();
    pll_lock = 0;
    set_req(1, 1, 2, 2, 1, 9, 1, 7);
    fire();
    wait_en(0);
    wait_en(1);
    for (int n = 0; n < EXP_TMO + 100 && !err; n++) @(negedge clk);
    chk("R11 timeout delay", c_err - c_enrise, EXP_TMO);
    chk("R11 safe clock", sysclk_pll, 0);
    chk("R11 not busy", busy, 0);
    set_req(0, 0, 8, 5, 2, 18, 2, 7);
    fire();
    chk("R11 err cleared by start", err, 0);
    wait_en(0);
    wait_en(1);
    repeat (2) @(negedge clk);
    lock_and_switch("R11 recovery");
    chk("R12 recovery mul", pll_mul, 18);
  endtask

  initial begin
    clear_marks();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold();
    t_up();
    t_down();
    t_equal();
    t_timeout();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule